// File: doc/BRIEF.md
# First-Party DMA Setup Interlock Gate

This block sits in a SATA host's receive path and decides what happens to an incoming DMA Setup frame (type code 0x41). A two-bit mode register chooses the policy. After reset the mode refuses every such frame with an error response. A pass mode accepts the frame at once. In interlocked mode the frame is parked, a flag drives the host interrupt, and the first header dword is shown to software. Nothing moves until software writes an accept or a reject strobe. The hardware does not interpret the frame's contents beyond its type and its direction bit.

Once a frame is accepted, the direction bit (bit 13 of the first dword) decides which DMA enables software may set. A value of 0 means the device reads host memory, so the outbound enable and the first-party write flag can be set. A value of 1 means the device writes host memory, so only the inbound enable can be set. No DMA Activate handshake comes before the data frames, and no completion status is returned. A count-exhausted strobe from the DMA engine clears every enable and frees the gate. A DMA Setup frame that arrives while one is parked or in transfer is refused, and the parked one is kept. If that refusal collides with software's decision on the parked frame, the refusal is queued for the next cycle.

States: `S_IDLE` waits for a frame. `S_WAIT_SW` holds a parked frame with the interrupt raised. `S_XFER` is the accepted transfer window. The transitions are:
- idle-to-wait: a frame arrives in interlocked mode.
- idle-to-xfer: a frame arrives in pass mode.
- idle-stay: a frame arrives in a refusing mode.
- wait-to-xfer: software accepts.
- wait-to-idle: software rejects.
- xfer-to-idle: the count-exhausted strobe.

Top module: `fis_intlk_gate`

## Requirements
- R1: After reset the mode reads 2'b00 (refuse), the interrupt is low, no response is requested and all three DMA enables are low.
- R2: In mode 2'b00 or 2'b11, a DMA Setup frame (first dword bits [7:0] = 0x41 with start-of-frame) produces, in the cycle after it, a one-cycle response request with resp_ok = 0 (error), and no interrupt.
- R3: In mode 2'b10, a DMA Setup frame raises the interrupt from the next cycle and exposes its first dword on fis_hdr and its bit 13 on fis_dir. No response is sent yet.
- R4: While a frame is parked, an accept strobe (without reject) gives a one-cycle response with resp_ok = 1 in the next cycle, drops the interrupt in that same cycle and opens the transfer window.
- R5: While a frame is parked, a reject strobe (alone or together with accept) gives a one-cycle response with resp_ok = 0, drops the interrupt and returns to idle, so that DMA enable set strobes then have no effect.
- R6: With direction 0 in the transfer window, the outbound-enable and first-party-write set strobes take effect in the next cycle, and the inbound set strobe has no effect.
- R7: With direction 1 in the transfer window, the inbound set strobe takes effect in the next cycle, and the outbound and first-party-write set strobes have no effect.
- R8: The count-exhausted strobe clears all DMA enables in the next cycle and ends the transfer window.
- R9: A DMA Setup frame arriving while one is parked or in transfer gets an error response. The interrupt, fis_hdr and fis_dir keep the parked frame's values.
- R10: Frames of other types, and words without start-of-frame, cause no response and no interrupt.
- R11: When software's decision and a refused second frame fall in the same cycle, software's response is sent first and the error response follows in the next cycle.
- R12: In mode 2'b01, a DMA Setup frame is answered with resp_ok = 1 in the next cycle without an interrupt, and the transfer window opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_valid | input | 1 | Receive word valid |
| rx_sof | input | 1 | Word is the first dword of a frame |
| rx_data | input | 32 | Receive dword |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 2 | Mode value written |
| sw_accept | input | 1 | Software accept strobe |
| sw_reject | input | 1 | Software reject strobe |
| sw_out_set | input | 1 | Set outbound DMA enable |
| sw_fpwr_set | input | 1 | Set first-party write flag |
| sw_in_set | input | 1 | Set inbound DMA enable |
| xfer_done | input | 1 | Transfer count exhausted strobe |
| cfg_mode | output | 2 | Current mode |
| irq | output | 1 | Interlock interrupt |
| fis_hdr | output | 32 | First dword of the held frame |
| fis_dir | output | 1 | Direction bit of the held frame |
| resp_req | output | 1 | One-cycle response request |
| resp_ok | output | 1 | 1 = good response, 0 = error response |
| dma_out_en | output | 1 | Outbound DMA enable |
| dma_in_en | output | 1 | Inbound DMA enable |
| fpdma_wr | output | 1 | First-party write flag |

## Verification
The assertions check on every cycle that:
- the refusing modes answer with an error;
- an interlocked arrival raises the interrupt;
- an accept yields a good response;
- a parked frame's direction stays put until software decides;
- a software response goes out ahead of a queued refusal;
- the inbound and outbound enables never coexist;
- the exhausted strobe clears every enable.

Only the bench scenarios can show the rest:
- that a set strobe for the wrong direction has no effect;
- that frames of other types are ignored;
- the exact two-cycle ordering in a collision;
- the complete accept, transfer and release sequences in each direction.

// File: rtl/fisgate_pkg.sv
package fisgate_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_WAIT_SW = 2'd1,
        S_XFER    = 2'd2
    } gate_state_t;

    typedef enum logic [1:0] {
        M_REFUSE = 2'b00,
        M_PASS   = 2'b01,
        M_INTLK  = 2'b10,
        M_RSVD   = 2'b11
    } gate_mode_t;

    localparam int NUM_EN = 3;
    localparam int EN_OUT = 0;
    localparam int EN_FPW = 1;
    localparam int EN_IN  = 2;

endpackage

// File: rtl/fis_type_sniffer.sv
module fis_type_sniffer #(
    parameter int          DW      = 32,
    parameter int          CODE_W  = 8,
    parameter int          DIR_BIT = 13,
    parameter logic [7:0]  CODE    = 8'h41
) (
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic [DW-1:0] rx_data,
    output logic          hit,
    output logic          hit_dir,
    output logic [DW-1:0] hit_hdr
);
    localparam logic [CODE_W-1:0] CODE_CMP = CODE_W'(CODE);

    logic type_match;

    assign type_match = (rx_data[CODE_W-1:0] == CODE_CMP);
    assign hit        = rx_valid && rx_sof && type_match;
    assign hit_hdr    = rx_data;

    generate
        if (DIR_BIT < DW) begin : g_dir
            assign hit_dir = rx_data[DIR_BIT];
        end else begin : g_nodir
            assign hit_dir = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/intlk_fsm.sv
module intlk_fsm
    import fisgate_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic          hit_dir,
    input  logic [DW-1:0] hit_hdr,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_wdata,
    input  logic          sw_accept,
    input  logic          sw_reject,
    input  logic          xfer_done,
    output gate_state_t   state,
    output logic [1:0]    mode,
    output logic          irq,
    output logic [DW-1:0] held_hdr,
    output logic          held_dir,
    output logic          prim_req,
    output logic          prim_ok,
    output logic          busy_rej
);
    gate_state_t state_q, state_n;
    logic [1:0]    mode_q;
    logic [DW-1:0] hdr_q;
    logic          dir_q;
    logic          latch_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // mode register and held frame fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
            hdr_q  <= '0;
            dir_q  <= 1'b0;
        end else begin
            if (cfg_we) mode_q <= cfg_wdata;
            if (latch_hit) begin
                hdr_q <= hit_hdr;
                dir_q <= hit_dir;
            end
        end
    end

    // next state and response decisions
    always_comb begin
        state_n   = state_q;
        prim_req  = 1'b0;
        prim_ok   = 1'b0;
        busy_rej  = 1'b0;
        latch_hit = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (hit) begin
                    unique case (gate_mode_t'(mode_q))
                        M_INTLK: begin
                            state_n   = S_WAIT_SW;
                            latch_hit = 1'b1;
                        end
                        M_PASS: begin
                            state_n   = S_XFER;
                            latch_hit = 1'b1;
                            prim_req  = 1'b1;
                            prim_ok   = 1'b1;
                        end
                        default: begin
                            prim_req = 1'b1;
                            prim_ok  = 1'b0;
                        end
                    endcase
                end
            end
            S_WAIT_SW: begin
                busy_rej = hit;
                if (sw_reject) begin
                    state_n  = S_IDLE;
                    prim_req = 1'b1;
                    prim_ok  = 1'b0;
                end else if (sw_accept) begin
                    state_n  = S_XFER;
                    prim_req = 1'b1;
                    prim_ok  = 1'b1;
                end
            end
            S_XFER: begin
                busy_rej = hit;
                if (xfer_done) state_n = S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    assign state    = state_q;
    assign mode     = mode_q;
    assign irq      = (state_q == S_WAIT_SW);
    assign held_hdr = hdr_q;
    assign held_dir = dir_q;

    AST_PARK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !sw_accept && !sw_reject) |=> (irq && $stable(held_dir) && $stable(held_hdr))); // R9

    AST_XFER_EXITS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_XFER && xfer_done) |=> (state_q == S_IDLE)); // R8

endmodule

// File: rtl/resp_arb.sv
module resp_arb #(
    parameter int DEFER_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prim_req,
    input  logic prim_ok,
    input  logic rej_req,
    output logic resp_req,
    output logic resp_ok
);
    localparam logic [DEFER_W-1:0] CNT_MAX = {DEFER_W{1'b1}};

    logic [DEFER_W-1:0] cnt_q, cnt_n;
    logic               req_n, ok_n;
    logic [DEFER_W:0]   sum;

    assign sum = {1'b0, cnt_q} + {{DEFER_W{1'b0}}, rej_req};

    always_comb begin
        req_n = 1'b0;
        ok_n  = 1'b0;
        cnt_n = cnt_q;
        if (prim_req) begin
            req_n = 1'b1;
            ok_n  = prim_ok;
            cnt_n = (sum > {1'b0, CNT_MAX}) ? CNT_MAX : sum[DEFER_W-1:0];
        end else if (sum != '0) begin
            req_n = 1'b1;
            ok_n  = 1'b0;
            cnt_n = DEFER_W'(sum - 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            resp_req <= 1'b0;
            resp_ok  <= 1'b0;
        end else begin
            cnt_q    <= cnt_n;
            resp_req <= req_n;
            resp_ok  <= ok_n;
        end
    end

    AST_PRIM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        prim_req |=> (resp_req && resp_ok == $past(prim_ok))); // R11

    AST_QUEUED_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_req && rej_req) |=> ##1 (resp_req && !resp_ok)); // R11

endmodule

// File: rtl/dma_en_ctl.sv
module dma_en_ctl
    import fisgate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic dir,
    input  logic out_set,
    input  logic fpwr_set,
    input  logic in_set,
    input  logic xfer_done,
    output logic out_en,
    output logic fpwr,
    output logic in_en
);
    // direction value under which each enable may be set
    localparam logic [NUM_EN-1:0] DIR_OF = 3'b100;

    logic [NUM_EN-1:0] set_v;
    logic [NUM_EN-1:0] en_q;

    assign set_v[EN_OUT] = out_set;
    assign set_v[EN_FPW] = fpwr_set;
    assign set_v[EN_IN]  = in_set;

    generate
        for (genvar i = 0; i < NUM_EN; i++) begin : g_en
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                    en_q[i] <= 1'b0;
                else if (xfer_done)                            en_q[i] <= 1'b0;
                else if (armed && set_v[i] && dir == DIR_OF[i]) en_q[i] <= 1'b1;
            end
        end
    endgenerate

    assign out_en = en_q[EN_OUT];
    assign fpwr   = en_q[EN_FPW];
    assign in_en  = en_q[EN_IN];

    AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        in_en |-> (!out_en && !fpwr)); // R7

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (!out_en && !fpwr && !in_en)); // R8

endmodule

// File: rtl/fis_intlk_gate.sv
module fis_intlk_gate
    import fisgate_pkg::*;
#(
    parameter int         DW         = 32,
    parameter int         CODE_W     = 8,
    parameter int         DIR_BIT    = 13,
    parameter logic [7:0] SETUP_CODE = 8'h41,
    parameter int         DEFER_W    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic [DW-1:0] rx_data,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_wdata,
    input  logic          sw_accept,
    input  logic          sw_reject,
    input  logic          sw_out_set,
    input  logic          sw_fpwr_set,
    input  logic          sw_in_set,
    input  logic          xfer_done,
    output logic [1:0]    cfg_mode,
    output logic          irq,
    output logic [DW-1:0] fis_hdr,
    output logic          fis_dir,
    output logic          resp_req,
    output logic          resp_ok,
    output logic          dma_out_en,
    output logic          dma_in_en,
    output logic          fpdma_wr
);
    gate_state_t   state;
    logic          hit, hit_dir;
    logic [DW-1:0] hit_hdr;
    logic          prim_req, prim_ok, busy_rej;

    fis_type_sniffer #(
        .DW(DW), .CODE_W(CODE_W), .DIR_BIT(DIR_BIT), .CODE(SETUP_CODE)
    ) u_sniff (
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
        .hit(hit), .hit_dir(hit_dir), .hit_hdr(hit_hdr)
    );

    intlk_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .hit(hit), .hit_dir(hit_dir), .hit_hdr(hit_hdr),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .sw_accept(sw_accept), .sw_reject(sw_reject), .xfer_done(xfer_done),
        .state(state), .mode(cfg_mode), .irq(irq),
        .held_hdr(fis_hdr), .held_dir(fis_dir),
        .prim_req(prim_req), .prim_ok(prim_ok), .busy_rej(busy_rej)
    );

    resp_arb #(.DEFER_W(DEFER_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .prim_req(prim_req), .prim_ok(prim_ok), .rej_req(busy_rej),
        .resp_req(resp_req), .resp_ok(resp_ok)
    );

    dma_en_ctl u_en (
        .clk(clk), .rst_n(rst_n),
        .armed(state == S_XFER), .dir(fis_dir),
        .out_set(sw_out_set), .fpwr_set(sw_fpwr_set), .in_set(sw_in_set),
        .xfer_done(xfer_done),
        .out_en(dma_out_en), .fpwr(fpdma_wr), .in_en(dma_in_en)
    );

    AST_REFUSE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && hit && !cfg_mode[0] && !cfg_mode[1]) |=> (resp_req && !resp_ok && !irq)); // R2

    AST_INTLK_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && hit && cfg_mode == 2'b10) |=> (irq && !resp_req)); // R3

    AST_ACCEPT_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && sw_accept && !sw_reject) |=> (resp_req && resp_ok && !irq)); // R4

    AST_REJECT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && sw_reject) |=> (resp_req && !resp_ok && !irq)); // R5

endmodule

// File: tb/tb_fis_intlk_gate.sv
`timescale 1ns/1ps
module tb_fis_intlk_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 0, rx_sof = 0;
    logic [31:0] rx_data = '0;
    logic        cfg_we = 0;
    logic [1:0]  cfg_wdata = '0;
    logic        sw_accept = 0, sw_reject = 0;
    logic        sw_out_set = 0, sw_fpwr_set = 0, sw_in_set = 0;
    logic        xfer_done = 0;
    logic [1:0]  cfg_mode;
    logic        irq, fis_dir, resp_req, resp_ok;
    logic [31:0] fis_hdr;
    logic        dma_out_en, dma_in_en, fpdma_wr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fis_intlk_gate dut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .sw_accept(sw_accept), .sw_reject(sw_reject),
        .sw_out_set(sw_out_set), .sw_fpwr_set(sw_fpwr_set), .sw_in_set(sw_in_set),
        .xfer_done(xfer_done),
        .cfg_mode(cfg_mode), .irq(irq), .fis_hdr(fis_hdr), .fis_dir(fis_dir),
        .resp_req(resp_req), .resp_ok(resp_ok),
        .dma_out_en(dma_out_en), .dma_in_en(dma_in_en), .fpdma_wr(fpdma_wr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr(input logic [7:0] code, input logic dir);
        return (32'(dir) << 13) | 32'(code) | 32'h00A0_0000;
    endfunction

    task automatic clear_inputs();
        rx_valid = 0; rx_sof = 0; rx_data = '0;
        cfg_we = 0; sw_accept = 0; sw_reject = 0;
        sw_out_set = 0; sw_fpwr_set = 0; sw_in_set = 0; xfer_done = 0;
    endtask

    task automatic step();
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic set_mode(input logic [1:0] m);
        cfg_we = 1; cfg_wdata = m;
        step();
    endtask

    task automatic send(input logic [7:0] code, input logic dir, input logic sof);
        rx_valid = 1; rx_sof = sof; rx_data = hdr(code, dir);
        step();
    endtask

    task automatic finish_xfer();
        xfer_done = 1;
        step();
        step();
    endtask

    task automatic t_reset();
        chk("R1 mode", 32'(cfg_mode), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 resp_req", 32'(resp_req), 32'd0);
        chk("R1 enables", 32'({dma_out_en, dma_in_en, fpdma_wr}), 32'd0);
    endtask

    task automatic t_refuse_modes();
        send(8'h41, 1'b0, 1'b1);
        chk("R2 resp_req", 32'(resp_req), 32'd1);
        chk("R2 resp_ok", 32'(resp_ok), 32'd0);
        chk("R2 irq", 32'(irq), 32'd0);
        step();
        chk("R2 one cycle", 32'(resp_req), 32'd0);
        set_mode(2'b11);
        send(8'h41, 1'b1, 1'b1);
        chk("R2 mode11 err", 32'({resp_req, resp_ok, irq}), 32'b100);
        step();
    endtask

    task automatic t_ignore_other();
        set_mode(2'b10);
        send(8'h34, 1'b0, 1'b1);
        chk("R10 other type resp", 32'(resp_req), 32'd0);
        chk("R10 other type irq", 32'(irq), 32'd0);
        send(8'h41, 1'b0, 1'b0);
        chk("R10 no sof", 32'({resp_req, irq}), 32'd0);
        step();
        chk("R10 still quiet", 32'({resp_req, irq}), 32'd0);
    endtask

    task automatic t_intlk_out();
        send(8'h41, 1'b0, 1'b1);
        chk("R3 irq", 32'(irq), 32'd1);
        chk("R3 no resp yet", 32'(resp_req), 32'd0);
        chk("R3 hdr", fis_hdr, hdr(8'h41, 1'b0));
        chk("R3 dir", 32'(fis_dir), 32'd0);
        sw_out_set = 1;
        step();
        chk("R6 set before accept ignored", 32'(dma_out_en), 32'd0);
        sw_accept = 1;
        step();
        chk("R4 resp", 32'({resp_req, resp_ok}), 32'b11);
        chk("R4 irq dropped", 32'(irq), 32'd0);
        sw_out_set = 1; sw_fpwr_set = 1; sw_in_set = 1;
        step();
        chk("R6 out_en", 32'(dma_out_en), 32'd1);
        chk("R6 fpdma_wr", 32'(fpdma_wr), 32'd1);
        chk("R6 in_en blocked", 32'(dma_in_en), 32'd0);
        chk("R4 resp one cycle", 32'(resp_req), 32'd0);
        xfer_done = 1;
        step();
        chk("R8 cleared", 32'({dma_out_en, dma_in_en, fpdma_wr}), 32'd0);
        sw_out_set = 1;
        step();
        chk("R8 window closed", 32'(dma_out_en), 32'd0);
    endtask

    task automatic t_intlk_in();
        send(8'h41, 1'b1, 1'b1);
        chk("R3 dir1", 32'(fis_dir), 32'd1);
        sw_accept = 1;
        step();
        chk("R4 resp dir1", 32'({resp_req, resp_ok}), 32'b11);
        sw_out_set = 1; sw_fpwr_set = 1;
        step();
        chk("R7 out blocked", 32'({dma_out_en, fpdma_wr}), 32'd0);
        sw_in_set = 1;
        step();
        chk("R7 in_en", 32'(dma_in_en), 32'd1);
        xfer_done = 1;
        step();
        chk("R8 in cleared", 32'(dma_in_en), 32'd0);
    endtask

    task automatic t_sw_reject();
        send(8'h41, 1'b0, 1'b1);
        sw_accept = 1; sw_reject = 1;
        step();
        chk("R5 resp err", 32'({resp_req, resp_ok}), 32'b10);
        chk("R5 irq dropped", 32'(irq), 32'd0);
        sw_out_set = 1; sw_fpwr_set = 1;
        step();
        chk("R5 no enable", 32'({dma_out_en, fpdma_wr}), 32'd0);
    endtask

    task automatic t_second_fis();
        send(8'h41, 1'b0, 1'b1);
        send(8'h41, 1'b1, 1'b1);
        chk("R9 refused", 32'({resp_req, resp_ok}), 32'b10);
        chk("R9 irq kept", 32'(irq), 32'd1);
        chk("R9 dir kept", 32'(fis_dir), 32'd0);
        chk("R9 hdr kept", fis_hdr, hdr(8'h41, 1'b0));
        sw_accept = 1;
        step();
        send(8'h41, 1'b1, 1'b1);
        chk("R9 refused in xfer", 32'({resp_req, resp_ok}), 32'b10);
        finish_xfer();
    endtask

    task automatic t_collision();
        send(8'h41, 1'b1, 1'b1);
        sw_accept = 1;
        rx_valid = 1; rx_sof = 1; rx_data = hdr(8'h41, 1'b0);
        step();
        chk("R11 first ok", 32'({resp_req, resp_ok}), 32'b11);
        step();
        chk("R11 then err", 32'({resp_req, resp_ok}), 32'b10);
        chk("R11 dir kept", 32'(fis_dir), 32'd1);
        step();
        chk("R11 done", 32'(resp_req), 32'd0);
        finish_xfer();
    endtask

    task automatic t_pass_mode();
        set_mode(2'b01);
        chk("R12 mode", 32'(cfg_mode), 32'd1);
        send(8'h41, 1'b1, 1'b1);
        chk("R12 resp ok", 32'({resp_req, resp_ok}), 32'b11);
        chk("R12 no irq", 32'(irq), 32'd0);
        sw_in_set = 1;
        step();
        chk("R12 window open", 32'(dma_in_en), 32'd1);
        finish_xfer();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_refuse_modes();
        t_ignore_other();
        t_intlk_out();
        t_intlk_in();
        t_sw_reject();
        t_second_fis();
        t_collision();
        t_pass_mode();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule